// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns a signed fixed-point angle into its sine and cosine using CORDIC rotation. Each rotation uses only arithmetic shifts and additions, so there are no multipliers. The angle may lie anywhere between minus two pi and plus two pi. Before the rotations start, a folding step maps it into the quarter-turn range where CORDIC converges, and remembers whether both results must be negated at the end.

The x register starts at the reciprocal of the accumulated CORDIC gain, so no multiplier is needed to correct the gain at the output. The number of rotations is a parameter. A second parameter groups several rotations into each pipeline register stage, which sets the latency. A third parameter removes every register, which makes the block fully combinational.

A new angle may be accepted on every clock cycle. A valid flag travels through the pipeline with each sample, so the output valid strobe marks exactly the cycles that carry results.

Top module: `sincos_cordic`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `result_valid` is low in the registered configurations, whatever `angle_valid` does.
- R2: `angle` is two's complement with ANG_W-4 fractional bits (14 by default). `sine` and `cosine` are two's complement with DATA_W-2 fractional bits (14 by default). For angles within plus or minus pi/2, each output is within 2^(DATA_W-1-N_ITER)+4 LSB of the true value.
- R3: Angles beyond plus or minus pi/2, up to and including plus or minus two pi, meet the same error bound as R2.
- R4: With ITER_PER_STAGE = 1, a result appears N_ITER+1 clock cycles after its angle is accepted.
- R5: When ITER_PER_STAGE divides N_ITER, a result appears 1 + N_ITER/ITER_PER_STAGE cycles after its angle is accepted. For example, N_ITER = 12 with ITER_PER_STAGE = 4 gives 4 cycles.
- R6: With ZERO_LAT = 1, the block is purely combinational. `result_valid` equals `angle_valid`, and results appear in the same cycle as their angle.
- R7: An angle can be accepted on every cycle. Every accepted angle yields exactly one result, and results come out in the order the angles were accepted.
- R8: A cycle with `angle_valid` low produces no result. The `angle` value present on that cycle has no effect on any result.
- R9: Asserting `rst` while samples are in flight discards them. None of those samples ever produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle | input | ANG_W | Signed angle in radians |
| angle_valid | input | 1 | Angle sample is valid |
| sine | output | DATA_W | Signed sine of the angle |
| cosine | output | DATA_W | Signed cosine of the angle |
| result_valid | output | 1 | Sine and cosine are valid |

## Verification
The assertions check three things on every cycle. First, the output valid strobe matches a shadow copy of the input strobe delayed by the configured latency, which also covers reset clearing. Second, each output stays within unit magnitude plus the error margin. Third, sine squared plus cosine squared stays close to one.

Some behaviours only the bench scenarios can show. These are the numeric agreement with real sine and cosine across all four quadrants and the folded range out to plus or minus two pi. They also include the exact sample-to-result cycle counts for the grouped and combinational variants, in-order delivery under back-to-back traffic, and the loss of samples cut off by a mid-stream reset.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // arctangent of 2^-i, by series for i >= 1 (argument <= 0.5)
  function automatic real atan_pow2(input int i);
    real v;
    real term;
    real acc;
    if (i == 0) return PI_R / 4.0;
    v    = 2.0 ** (-i);
    acc  = 0.0;
    term = v;
    for (int k = 0; k < 40; k++) begin
      if ((k % 2) == 0) acc = acc + term / (2 * k + 1);
      else              acc = acc - term / (2 * k + 1);
      term = term * v * v;
    end
    return acc;
  endfunction

  // reciprocal of the CORDIC gain after n rotations
  function automatic real inv_gain(input int n);
    real p;
    real s;
    p = 1.0;
    for (int i = 0; i < n; i++) p = p * (1.0 + 2.0 ** (-2 * i));
    s = 1.0;
    for (int k = 0; k < 40; k++) s = 0.5 * (s + p / s);
    return 1.0 / s;
  endfunction

  function automatic longint to_fix(input real r, input int frac);
    return longint'(r * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/sincos_range_fold.sv
module sincos_range_fold #(
  parameter int ANG_W = 18,
  parameter int ZW    = 19,
  parameter int AF    = 14
) (
  input  logic signed [ANG_W-1:0] angle,
  output logic signed [ZW-1:0]    z_o,
  output logic                    flip_o
);
  localparam logic signed [ZW-1:0] PI_F  = ZW'(sincos_pkg::to_fix(sincos_pkg::PI_R, AF));
  localparam logic signed [ZW-1:0] PI2_F = ZW'(sincos_pkg::to_fix(2.0 * sincos_pkg::PI_R, AF));
  localparam logic signed [ZW-1:0] HPI_F = ZW'(sincos_pkg::to_fix(0.5 * sincos_pkg::PI_R, AF));

  logic signed [ZW-1:0] ext;
  logic signed [ZW-1:0] wrapped;

  assign ext = ZW'(angle);

  // first fold: full turn into [-pi, pi]
  always_comb begin
    if (ext > PI_F)       wrapped = ext - PI2_F;
    else if (ext < -PI_F) wrapped = ext + PI2_F;
    else                  wrapped = ext;
  end

  // second fold: half turn into [-pi/2, pi/2], remembering the sign flip
  always_comb begin
    flip_o = 1'b0;
    z_o    = wrapped;
    if (wrapped > HPI_F) begin
      z_o    = wrapped - PI_F;
      flip_o = 1'b1;
    end else if (wrapped < -HPI_F) begin
      z_o    = wrapped + PI_F;
      flip_o = 1'b1;
    end
  end
endmodule

// File: rtl/sincos_iter_stage.sv
module sincos_iter_stage #(
  parameter int XW    = 20,
  parameter int ZW    = 19,
  parameter int AF    = 14,
  parameter int FIRST = 0,
  parameter int CNT   = 1,
  parameter bit REG   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic                 flip_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 vld_o,
  output logic                 flip_o,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [XW-1:0] xs [0:CNT];
  logic signed [XW-1:0] ys [0:CNT];
  logic signed [ZW-1:0] zs [0:CNT];

  assign xs[0] = x_i;
  assign ys[0] = y_i;
  assign zs[0] = z_i;

  for (genvar j = 0; j < CNT; j++) begin : g_rot
    localparam int SH = FIRST + j;
    localparam logic signed [ZW-1:0] ATN =
      ZW'(sincos_pkg::to_fix(sincos_pkg::atan_pow2(SH), AF));
    logic neg;
    assign neg       = zs[j][ZW-1];
    assign xs[j+1]   = neg ? xs[j] + (ys[j] >>> SH) : xs[j] - (ys[j] >>> SH);
    assign ys[j+1]   = neg ? ys[j] - (xs[j] >>> SH) : ys[j] + (xs[j] >>> SH);
    assign zs[j+1]   = neg ? zs[j] + ATN : zs[j] - ATN;
  end

  if (REG) begin : g_reg
    always_ff @(posedge clk) begin
      vld_o  <= rst ? 1'b0 : vld_i;
      flip_o <= flip_i;
      x_o    <= xs[CNT];
      y_o    <= ys[CNT];
      z_o    <= zs[CNT];
    end
  end else begin : g_comb
    assign vld_o  = vld_i;
    assign flip_o = flip_i;
    assign x_o    = xs[CNT];
    assign y_o    = ys[CNT];
    assign z_o    = zs[CNT];
  end
endmodule

// File: rtl/sincos_post.sv
module sincos_post #(
  parameter int XW     = 20,
  parameter int DATA_W = 16,
  parameter int GUARD  = 4
) (
  input  logic                     flip_i,
  input  logic signed [XW-1:0]     x_i,
  input  logic signed [XW-1:0]     y_i,
  output logic signed [DATA_W-1:0] sine,
  output logic signed [DATA_W-1:0] cosine
);
  localparam logic signed [XW-1:0] HALF = XW'(1) <<< (GUARD - 1);

  logic signed [DATA_W-1:0] s_r;
  logic signed [DATA_W-1:0] c_r;

  assign s_r    = DATA_W'((y_i + HALF) >>> GUARD);
  assign c_r    = DATA_W'((x_i + HALF) >>> GUARD);
  assign sine   = flip_i ? -s_r : s_r;
  assign cosine = flip_i ? -c_r : c_r;
endmodule

// File: rtl/sincos_cordic.sv
module sincos_cordic #(
  parameter int ANG_W          = 18,
  parameter int DATA_W         = 16,
  parameter int GUARD          = 4,
  parameter int N_ITER         = 11,
  parameter int ITER_PER_STAGE = 1,
  parameter bit ZERO_LAT       = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [ANG_W-1:0]  angle,
  input  logic                     angle_valid,
  output logic signed [DATA_W-1:0] sine,
  output logic signed [DATA_W-1:0] cosine,
  output logic                     result_valid
);
  localparam int XW   = DATA_W + GUARD;
  localparam int XF   = DATA_W - 2 + GUARD;
  localparam int ZW   = ANG_W + 1;
  localparam int AF   = ANG_W - 4;
  localparam int NSTG = N_ITER / ITER_PER_STAGE;
  localparam int LAT  = ZERO_LAT ? 0 : NSTG + 1;
  localparam logic signed [XW-1:0] X0 =
    XW'(sincos_pkg::to_fix(sincos_pkg::inv_gain(N_ITER), XF));

  logic signed [ZW-1:0] z_f;
  logic                 flip_f;

  logic                 vld_p  [0:NSTG];
  logic                 flip_p [0:NSTG];
  logic signed [XW-1:0] x_p    [0:NSTG];
  logic signed [XW-1:0] y_p    [0:NSTG];
  logic signed [ZW-1:0] z_p    [0:NSTG];

  sincos_range_fold #(.ANG_W(ANG_W), .ZW(ZW), .AF(AF)) fold_i (
    .angle  (angle),
    .z_o    (z_f),
    .flip_o (flip_f)
  );

  // entry register: folded angle and gain-compensated start vector
  sincos_iter_stage #(
    .XW(XW), .ZW(ZW), .AF(AF), .FIRST(0), .CNT(0), .REG(!ZERO_LAT)
  ) entry_i (
    .clk(clk), .rst(rst),
    .vld_i(angle_valid), .flip_i(flip_f), .x_i(X0), .y_i('0), .z_i(z_f),
    .vld_o(vld_p[0]), .flip_o(flip_p[0]), .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
  );

  for (genvar s = 1; s <= NSTG; s++) begin : g_stg
    sincos_iter_stage #(
      .XW(XW), .ZW(ZW), .AF(AF),
      .FIRST((s - 1) * ITER_PER_STAGE), .CNT(ITER_PER_STAGE), .REG(!ZERO_LAT)
    ) stage_i (
      .clk(clk), .rst(rst),
      .vld_i(vld_p[s-1]), .flip_i(flip_p[s-1]),
      .x_i(x_p[s-1]), .y_i(y_p[s-1]), .z_i(z_p[s-1]),
      .vld_o(vld_p[s]), .flip_o(flip_p[s]),
      .x_o(x_p[s]), .y_o(y_p[s]), .z_o(z_p[s])
    );
  end

  sincos_post #(.XW(XW), .DATA_W(DATA_W), .GUARD(GUARD)) post_i (
    .flip_i (flip_p[NSTG]),
    .x_i    (x_p[NSTG]),
    .y_i    (y_p[NSTG]),
    .sine   (sine),
    .cosine (cosine)
  );

  assign result_valid = vld_p[NSTG];
endmodule

// File: rtl/sincos_cordic_chk.sv
module sincos_cordic_chk #(
  parameter int DATA_W = 16,
  parameter int N_ITER = 11,
  parameter int LAT    = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_vld,
  input logic                     out_vld,
  input logic signed [DATA_W-1:0] sin_v,
  input logic signed [DATA_W-1:0] cos_v
);
  localparam longint ONE  = longint'(1) << (DATA_W - 2);
  localparam longint TOLL = (longint'(1) << (DATA_W - 1 - N_ITER)) + 4;

  longint mag2;
  assign mag2 = longint'(sin_v) * longint'(sin_v) + longint'(cos_v) * longint'(cos_v);

  if (LAT > 0) begin : g_seq
    logic [LAT-1:0] shadow;
    always_ff @(posedge clk) begin
      if (rst) shadow <= '0;
      else     shadow <= (shadow << 1) | LAT'(in_vld);
    end

    // R4 and R5: valid strobe delayed by exactly the configured latency
    assert_valid_align_R4: assert property (@(posedge clk) disable iff (rst)
      out_vld == shadow[LAT-1]);

    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> !out_vld);
  end else begin : g_comb
    assert_valid_pass_R6: assert property (@(posedge clk)
      out_vld == in_vld);
  end

  assert_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (longint'(sin_v) <= ONE + TOLL && longint'(sin_v) >= -ONE - TOLL &&
                 longint'(cos_v) <= ONE + TOLL && longint'(cos_v) >= -ONE - TOLL));

  assert_unit_circle_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (mag2 <= ONE * ONE + 4 * ONE * TOLL && mag2 >= ONE * ONE - 4 * ONE * TOLL));
endmodule

bind sincos_cordic sincos_cordic_chk #(
  .DATA_W(DATA_W), .N_ITER(N_ITER), .LAT(LAT)
) chk_i (
  .clk(clk), .rst(rst), .in_vld(angle_valid), .out_vld(result_valid),
  .sin_v(sine), .cos_v(cosine)
);

// File: tb/sincos_cordic_tb.sv
`timescale 1ns/1ps
module sincos_cordic_tb_top;
  localparam int  ANG_W  = 18;
  localparam int  DATA_W = 16;
  localparam real SCALE  = 16384.0;
  localparam real PI     = 3.14159265358979323846;
  localparam int  LAT_A  = 12;  // N=11, one rotation per stage
  localparam int  LAT_G  = 4;   // N=12, four rotations per stage
  localparam int  N_A    = 11;
  localparam int  N_G    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [ANG_W-1:0] angle = '0;
  logic angle_valid = 1'b0;

  logic signed [DATA_W-1:0] s0, c0, s1, c1, s2, c2;
  logic v0, v1, v2;

  always #4 clk = ~clk;  // 125 MHz

  sincos_cordic #(.N_ITER(N_A), .ITER_PER_STAGE(1)) dut_i (
    .clk(clk), .rst(rst), .angle(angle), .angle_valid(angle_valid),
    .sine(s0), .cosine(c0), .result_valid(v0));
  sincos_cordic #(.N_ITER(N_G), .ITER_PER_STAGE(4)) dut_g_i (
    .clk(clk), .rst(rst), .angle(angle), .angle_valid(angle_valid),
    .sine(s1), .cosine(c1), .result_valid(v1));
  sincos_cordic #(.N_ITER(N_A), .ZERO_LAT(1'b1)) dut_z_i (
    .clk(clk), .rst(rst), .angle(angle), .angle_valid(angle_valid),
    .sine(s2), .cosine(c2), .result_valid(v2));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int sent_ang [0:2047];
  int sent_cyc [0:2047];
  int n_sent = 0;
  int rd [0:2];
  int got [0:2];
  int stray = 0;

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  function automatic int tol_for(input int n);
    return (1 << (DATA_W - 1 - n)) + 4;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    end
  endtask

  task automatic mon(input int d, input logic v, input logic signed [DATA_W-1:0] s,
                     input logic signed [DATA_W-1:0] c, input int lat, input int n_it,
                     input string lreq);
    real a, es, ec;
    string req;
    if (!v) return;
    if (rd[d] >= n_sent) begin
      stray++;
      check(1'b0, "R8", $sformatf("dut%0d result with no pending sample", d), 1.0, 0.0);
      return;
    end
    a   = real'(sent_ang[rd[d]]) / SCALE;
    req = (a > PI / 2.0 || a < -PI / 2.0) ? "R3" : "R2";
    es  = $sin(a) * SCALE;
    ec  = $cos(a) * SCALE;
    check(rabs(real'(s) - es) <= real'(tol_for(n_it)), req,
          $sformatf("dut%0d sine at %0f rad", d, a), real'(s), es);
    check(rabs(real'(c) - ec) <= real'(tol_for(n_it)), req,
          $sformatf("dut%0d cosine at %0f rad", d, a), real'(c), ec);
    check((cyc - sent_cyc[rd[d]]) == lat, lreq, $sformatf("dut%0d latency", d),
          real'(cyc - sent_cyc[rd[d]]), real'(lat));
    rd[d]++;
    got[d]++;
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst) begin
      mon(0, v0, s0, c0, LAT_A, N_A, "R4");
      mon(1, v1, s1, c1, LAT_G, N_G, "R5");
      mon(2, v2, s2, c2, 0,     N_A, "R6");
    end
  end

  task automatic send(input real a);
    @(negedge clk);
    angle       = ANG_W'(int'(a * SCALE));
    angle_valid = 1'b1;
    sent_ang[n_sent] = int'(angle);
    sent_cyc[n_sent] = cyc;
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      angle_valid = 1'b0;
      angle       = ANG_W'($urandom);
    end
  endtask

  // R1: registered variants keep result_valid low through reset
  task automatic t_reset_state();
    rst = 1'b1;
    idle(2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      angle       = ANG_W'(int'(0.5 * SCALE));
      angle_valid = 1'b1;
      #1;
      check(v0 == 1'b0, "R1", "dut0 valid in reset", real'(v0), 0.0);
      check(v1 == 1'b0, "R1", "dut1 valid in reset", real'(v1), 0.0);
    end
    @(negedge clk);
    angle_valid = 1'b0;
    rst         = 1'b0;
    #1;
    check(v0 == 1'b0, "R1", "dut0 valid after reset", real'(v0), 0.0);
    check(v1 == 1'b0, "R1", "dut1 valid after reset", real'(v1), 0.0);
    idle(LAT_A + 2);
  endtask

  // R2, R3, R7: back-to-back sweep over the full range, endpoints included
  task automatic t_sweep();
    int g0, g1, g2;
    g0 = got[0]; g1 = got[1]; g2 = got[2];
    for (int k = -64; k <= 64; k++) send(real'(k) * 2.0 * PI / 64.0);
    idle(LAT_A + 3);
    check(got[0] - g0 == 129, "R7", "dut0 sweep results", real'(got[0] - g0), 129.0);
    check(got[1] - g1 == 129, "R7", "dut1 sweep results", real'(got[1] - g1), 129.0);
    check(got[2] - g2 == 129, "R7", "dut2 sweep results", real'(got[2] - g2), 129.0);
  endtask

  // R8: random angles with idle gaps carrying junk angle values
  task automatic t_random_gaps();
    int g0, g1, g2, ns;
    g0 = got[0]; g1 = got[1]; g2 = got[2]; ns = 0;
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(2) == 0) idle(1);
      else begin
        send((real'(int'($urandom_range(200000)) - 100000) / 100000.0) * 2.0 * PI);
        ns++;
      end
    end
    idle(LAT_A + 3);
    check(got[0] - g0 == ns, "R8", "dut0 result count", real'(got[0] - g0), real'(ns));
    check(got[1] - g1 == ns, "R8", "dut1 result count", real'(got[1] - g1), real'(ns));
    check(got[2] - g2 == ns, "R8", "dut2 result count", real'(got[2] - g2), real'(ns));
  endtask

  // R4, R5, R6: isolated samples near the fold boundaries
  task automatic t_isolated();
    send(PI / 2.0 + 0.001);  idle(LAT_A + 2);
    send(-PI / 2.0 - 0.001); idle(LAT_A + 2);
    send(PI + 0.002);        idle(LAT_A + 2);
    send(-2.0 * PI + 0.01);  idle(LAT_A + 2);
  endtask

  // R9: a reset while samples are in flight discards them
  task automatic t_midreset();
    int st;
    st = stray;
    send(1.0);
    send(-2.5);
    @(negedge clk);
    angle_valid = 1'b0;
    rst         = 1'b1;
    rd[0]       = n_sent;
    rd[1]       = n_sent;
    @(negedge clk);
    rst = 1'b0;
    idle(LAT_A + 4);
    check(stray == st, "R9", "results from discarded samples", real'(stray - st), 0.0);
    send(0.75);
    idle(LAT_A + 3);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rd[0] = 0; rd[1] = 0; rd[2] = 0;
    got[0] = 0; got[1] = 0; got[2] = 0;
    t_reset_state();
    t_sweep();
    t_random_gaps();
    t_isolated();
    t_midreset();
    for (int d = 0; d < 3; d++)
      check(rd[d] == n_sent, "R7", $sformatf("dut%0d delivered all samples", d),
            real'(rd[d]), real'(n_sent));
    finish_run();
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule